// File: doc/BRIEF.md
# Delayed-Response Eating Evaluator

This block scores a grid agent that may only eat after waiting on a resource cell for a set number of steps. Once per step the agent's controller presents the contents of the current cell, a flag saying whether the agent entered a new cell, three movement bits (forward, turn left, turn right) and a mouth-close bit. The block counts how many consecutive steps the agent has stayed still on the same resource. It accepts a mouth closure as eating only when that closure lands on exactly the K-th still step.

It keeps a tally of food and of poison eaten, and a signed fitness equal to their difference. It also runs a lifespan budget that only non-waiting steps draw from. When the budget reaches zero the evaluation is finished, and later steps change nothing. K and the budget are taken from input ports while reset is held. This lets an evaluation harness run a fresh agent with new settings after every reset.

Top module: `eat_eval`

## Requirements
- R1: While `rst_n` is low (reset is synchronous), the block loads K from `waitTarget` and the budget from `lifeBudget`. On release, `waitCount`, `foodCount`, `poisonCount` and `fitness` are zero, `eatPulse` is low, `lifeLeft` equals the loaded budget, and `done` is high exactly when that budget is zero.
- R2: Cell codes are 2'b01 for food and 2'b10 for poison; 2'b00 and 2'b11 hold no resource. A still step is a valid step on a food or poison cell, with `cellChange`, `moveFwd`, `turnLeft` and `turnRight` all low. A still step that does not eat raises `waitCount` by one, visible one cycle after the step.
- R3: Any valid step that is not a still step clears `waitCount` to zero. This covers any movement bit, a cell change, or a cell without a resource.
- R4: `waitCount` saturates at K+1, so a long wait never wraps back to K.
- R5: A still step with `mouthClose` high, where the wait count reaches exactly K, is an eat. On the next cycle `eatPulse` is high for one cycle, `waitCount` is zero, and `foodCount` or `poisonCount` (chosen by the cell code) has risen by one.
- R6: A mouth closure on a still step that reaches any count other than K leaves the tallies and fitness unchanged and `eatPulse` low. The wait count keeps advancing.
- R7: `fitness` is a signed value that always equals `foodCount` minus `poisonCount`. Food raises it by one; poison lowers it by one.
- R8: Each non-still valid step lowers `lifeLeft` by one. Still steps, including the eating step, leave it unchanged.
- R9: `done` is high when `lifeLeft` is zero. After that, valid steps change no output, and `eatPulse` stays low.
- R10: A cycle with `stepValid` low changes no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads settings |
| waitTarget | input | KW | Required wait K, sampled in reset |
| lifeBudget | input | LW | Lifespan budget, sampled in reset |
| stepValid | input | 1 | One agent step this cycle |
| cellKind | input | 2 | Cell contents code |
| cellChange | input | 1 | Agent is on a different cell than last step |
| moveFwd | input | 1 | Forward motor bit |
| turnLeft | input | 1 | Left-turn motor bit |
| turnRight | input | 1 | Right-turn motor bit |
| mouthClose | input | 1 | Mouth closes this step |
| waitCount | output | KW+1 | Consecutive still steps |
| foodCount | output | CW | Food items eaten |
| poisonCount | output | CW | Poison items eaten |
| fitness | output | CW+1 | Signed food minus poison |
| lifeLeft | output | LW | Remaining lifespan steps |
| done | output | 1 | Lifespan exhausted |
| eatPulse | output | 1 | One-cycle pulse marking the cell consumed |

## Verification
The assertions take for granted that K loaded in reset is at least one. With K equal to zero no still step can reach the target. The fitness check also assumes that neither tally reaches its saturation limit; at that point fitness stops moving.

The stimulus keeps K at one or three. It keeps the budget small, so that the tallies stay far below their limits. Every step is driven as a single-cycle `stepValid` pulse, away from the clock edge.

// File: rtl/eat_eval_pkg.sv
`timescale 1ns/1ps
package eat_eval_pkg;

  typedef enum logic [1:0] {
    CELL_EMPTY  = 2'b00,
    CELL_FOOD   = 2'b01,
    CELL_POISON = 2'b10,
    CELL_WALL   = 2'b11
  } cell_e;

  // strobes from control to datapath, one step's worth
  typedef struct packed {
    logic clrWait;
    logic incWait;
    logic eatFood;
    logic eatPoison;
    logic chargeLife;
  } step_stb_t;

endpackage

// File: rtl/eat_ctrl.sv
`timescale 1ns/1ps
module eat_ctrl
  import eat_eval_pkg::*;
#(
  parameter int KW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stepValid,
  input  logic [1:0]    cellKind,
  input  logic          cellChange,
  input  logic          moveFwd,
  input  logic          turnLeft,
  input  logic          turnRight,
  input  logic          mouthClose,
  input  logic [KW:0]   waitCount,
  input  logic [KW-1:0] waitTgt,
  input  logic          done,
  output step_stb_t     stb
);

  localparam int HW = KW + 2;

  logic          moving;
  logic          onFood;
  logic          onPoison;
  logic          still;
  logic          active;
  logic          hitTarget;
  logic          eatNow;
  logic [HW-1:0] nextCount;
  logic [HW-1:0] tgtWide;

  always_comb begin
    moving    = moveFwd | turnLeft | turnRight;
    onFood    = (cellKind == CELL_FOOD);
    onPoison  = (cellKind == CELL_POISON);
    still     = !moving && !cellChange && (onFood || onPoison);
    active    = stepValid && !done;
    nextCount = {1'b0, waitCount} + HW'(1);
    tgtWide   = {2'b00, waitTgt};
    hitTarget = (nextCount == tgtWide);
    eatNow    = active && still && mouthClose && hitTarget;

    stb            = '0;
    stb.eatFood    = eatNow && onFood;
    stb.eatPoison  = eatNow && onPoison;
    stb.clrWait    = active && (!still || eatNow);
    stb.incWait    = active && still && !eatNow;
    stb.chargeLife = active && !still;
  end

  // a finished evaluation issues no strobes at all
  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stb == '0));

  // a step that moves can never be charged as waiting and eat at once
  assert_move_no_eat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (stepValid && moving) |-> !(stb.eatFood || stb.eatPoison));

endmodule

// File: rtl/eat_dp.sv
`timescale 1ns/1ps
module eat_dp
  import eat_eval_pkg::*;
#(
  parameter int KW = 4,
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [KW-1:0]       waitTarget,
  input  logic [LW-1:0]       lifeBudget,
  input  step_stb_t           stb,
  output logic [KW:0]         waitCount,
  output logic [KW-1:0]       waitTgt,
  output logic [CW-1:0]       foodCount,
  output logic [CW-1:0]       poisonCount,
  output logic signed [CW:0]  fitness,
  output logic [LW-1:0]       lifeLeft,
  output logic                done,
  output logic                eatPulse
);

  localparam logic [CW-1:0] TALLY_MAX = '1;

  logic [KW:0] satLimit;

  assign satLimit = {1'b0, waitTgt} + (KW+1)'(1);
  assign done     = (lifeLeft == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waitTgt     <= waitTarget;
      lifeLeft    <= lifeBudget;
      waitCount   <= '0;
      foodCount   <= '0;
      poisonCount <= '0;
      fitness     <= '0;
      eatPulse    <= 1'b0;
    end else begin
      eatPulse <= stb.eatFood | stb.eatPoison;

      if (stb.clrWait)
        waitCount <= '0;
      else if (stb.incWait && (waitCount != satLimit))
        waitCount <= waitCount + (KW+1)'(1);

      if (stb.eatFood && (foodCount != TALLY_MAX)) begin
        foodCount <= foodCount + CW'(1);
        fitness   <= fitness + (CW+1)'(1);
      end else if (stb.eatPoison && (poisonCount != TALLY_MAX)) begin
        poisonCount <= poisonCount + CW'(1);
        fitness     <= fitness - (CW+1)'(1);
      end

      if (stb.chargeLife && (lifeLeft != '0))
        lifeLeft <= lifeLeft - LW'(1);
    end
  end

  assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    waitCount <= satLimit);

  assert_fitness_diff_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fitness == ($signed({1'b0, foodCount}) - $signed({1'b0, poisonCount})));

  assert_wait_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.incWait || stb.eatFood || stb.eatPoison) |=> $stable(lifeLeft));

  assert_done_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(lifeLeft) && $stable(foodCount) && $stable(poisonCount)
              && $stable(fitness)));

  assert_eat_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eatPulse |-> (waitCount == '0));

  assert_eat_on_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    eatPulse |-> (({1'b0, $past(waitCount)} + (KW+2)'(1)) == {2'b00, waitTgt}));

endmodule

// File: rtl/eat_eval.sv
`timescale 1ns/1ps
module eat_eval
  import eat_eval_pkg::*;
#(
  parameter int KW = 4,
  parameter int LW = 8,
  parameter int CW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [KW-1:0]      waitTarget,
  input  logic [LW-1:0]      lifeBudget,
  input  logic               stepValid,
  input  logic [1:0]         cellKind,
  input  logic               cellChange,
  input  logic               moveFwd,
  input  logic               turnLeft,
  input  logic               turnRight,
  input  logic               mouthClose,
  output logic [KW:0]        waitCount,
  output logic [CW-1:0]      foodCount,
  output logic [CW-1:0]      poisonCount,
  output logic signed [CW:0] fitness,
  output logic [LW-1:0]      lifeLeft,
  output logic               done,
  output logic               eatPulse
);

  step_stb_t     stb;
  logic [KW-1:0] waitTgt;

  eat_ctrl #(.KW(KW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .stepValid  (stepValid),
    .cellKind   (cellKind),
    .cellChange (cellChange),
    .moveFwd    (moveFwd),
    .turnLeft   (turnLeft),
    .turnRight  (turnRight),
    .mouthClose (mouthClose),
    .waitCount  (waitCount),
    .waitTgt    (waitTgt),
    .done       (done),
    .stb        (stb)
  );

  eat_dp #(.KW(KW), .LW(LW), .CW(CW)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .waitTarget  (waitTarget),
    .lifeBudget  (lifeBudget),
    .stb         (stb),
    .waitCount   (waitCount),
    .waitTgt     (waitTgt),
    .foodCount   (foodCount),
    .poisonCount (poisonCount),
    .fitness     (fitness),
    .lifeLeft    (lifeLeft),
    .done        (done),
    .eatPulse    (eatPulse)
  );

endmodule

// File: tb/eat_eval_test.sv
`timescale 1ns/1ps
module eat_eval_test;

  localparam int KW = 4;
  localparam int LW = 8;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [KW-1:0] waitTarget = '0;
  logic [LW-1:0] lifeBudget = '0;
  logic stepValid = 1'b0;
  logic [1:0] cellKind = 2'b00;
  logic cellChange = 1'b0, moveFwd = 1'b0, turnLeft = 1'b0, turnRight = 1'b0;
  logic mouthClose = 1'b0;
  logic [KW:0] waitCount;
  logic [CW-1:0] foodCount, poisonCount;
  logic signed [CW:0] fitness;
  logic [LW-1:0] lifeLeft;
  logic done, eatPulse;

  eat_eval #(.KW(KW), .LW(LW), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .waitTarget(waitTarget), .lifeBudget(lifeBudget),
    .stepValid(stepValid), .cellKind(cellKind), .cellChange(cellChange),
    .moveFwd(moveFwd), .turnLeft(turnLeft), .turnRight(turnRight),
    .mouthClose(mouthClose), .waitCount(waitCount), .foodCount(foodCount),
    .poisonCount(poisonCount), .fitness(fitness), .lifeLeft(lifeLeft),
    .done(done), .eatPulse(eatPulse)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int    wcnt;
    int    food;
    int    pois;
    int    fit;
    int    life;
    int    dn;
    int    pulse;
    string req;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int bad = 0;
  bit finished = 0;

  // requirement model state
  int mK, mWait, mFood, mPois, mLife;

  task automatic chk(string req, string what, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic compareAll(exp_t e);
    chk(e.req, "waitCount", int'(waitCount), e.wcnt);
    chk(e.req, "foodCount", int'(foodCount), e.food);
    chk(e.req, "poisonCount", int'(poisonCount), e.pois);
    chk(e.req, "fitness", int'(fitness), e.fit);
    chk(e.req, "lifeLeft", int'(lifeLeft), e.life);
    chk(e.req, "done", int'(done), e.dn);
    chk(e.req, "eatPulse", int'(eatPulse), e.pulse);
  endtask

  function automatic exp_t snap(int pulse, string req);
    exp_t e;
    e.wcnt = mWait; e.food = mFood; e.pois = mPois; e.fit = mFood - mPois;
    e.life = mLife; e.dn = (mLife == 0) ? 1 : 0; e.pulse = pulse; e.req = req;
    return e;
  endfunction

  // monitor: results of the edge just passed
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      compareAll(e);
    end
  end

  task automatic doReset(int k, int budget);
    @(negedge clk);
    stepValid = 1'b0;
    rst_n = 1'b0;
    waitTarget = KW'(k);
    lifeBudget = LW'(budget);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    mK = k; mWait = 0; mFood = 0; mPois = 0; mLife = budget;
    compareAll(snap(0, "R1"));
  endtask

  task automatic idle(string req);
    @(negedge clk);
    stepValid = 1'b0;
    cellKind = 2'b01; mouthClose = 1'b1;
    q.push_back(snap(0, req));
  endtask

  task automatic step(logic [1:0] kind, bit chg, bit f, bit l, bit r, bit m,
                      string req);
    bit still;
    int nw;
    int pulse;
    @(negedge clk);
    stepValid = 1'b1; cellKind = kind; cellChange = chg;
    moveFwd = f; turnLeft = l; turnRight = r; mouthClose = m;
    pulse = 0;
    if (mLife != 0) begin
      still = !(f || l || r) && !chg && (kind == 2'b01 || kind == 2'b10);
      if (still) begin
        nw = (mWait + 1 > mK + 1) ? mK + 1 : mWait + 1;
        if (m && nw == mK) begin
          pulse = 1;
          mWait = 0;
          if (kind == 2'b01) mFood++; else mPois++;
        end else begin
          mWait = nw;
        end
      end else begin
        mWait = 0;
        mLife--;
      end
    end
    q.push_back(snap(pulse, req));
  endtask

  initial begin
    doReset(3, 10);
    idle("R10");
    // food eaten on exactly the third still step
    step(2'b01, 0, 0, 0, 0, 0, "R2");
    step(2'b01, 0, 0, 0, 0, 0, "R2");
    step(2'b01, 0, 0, 0, 0, 1, "R5");
    idle("R5_pulse_drop");
    step(2'b01, 0, 1, 0, 0, 0, "R3_R8");
    // poison: early and late closures do nothing
    step(2'b10, 0, 0, 0, 0, 0, "R2");
    step(2'b10, 0, 0, 0, 0, 1, "R6");
    step(2'b10, 0, 0, 0, 0, 0, "R2");
    step(2'b10, 0, 0, 0, 0, 1, "R6");
    step(2'b10, 0, 0, 0, 0, 0, "R4");
    step(2'b10, 0, 0, 0, 0, 1, "R4");
    step(2'b10, 0, 0, 1, 0, 0, "R3");
    // two poison eats push fitness negative
    for (int n = 0; n < 2; n++) begin
      step(2'b10, 0, 0, 0, 0, 0, "R8");
      step(2'b10, 0, 0, 0, 0, 0, "R8");
      step(2'b10, 0, 0, 0, 0, 1, "R7");
      step(2'b10, 1, 0, 0, 0, 0, "R3");
    end
    // clears from cell change, empty cell, wall and right turn
    step(2'b01, 0, 0, 0, 0, 0, "R2");
    step(2'b01, 1, 0, 0, 0, 1, "R3");
    step(2'b01, 0, 0, 0, 0, 0, "R2");
    step(2'b00, 0, 0, 0, 0, 1, "R3");
    step(2'b11, 0, 0, 0, 0, 0, "R3");
    step(2'b01, 0, 0, 0, 0, 0, "R2");
    step(2'b01, 0, 0, 0, 1, 1, "R3");
    idle("R10");
    // burn the rest of the budget
    while (mLife > 0) step(2'b00, 0, 1, 0, 0, 0, "R8");
    step(2'b01, 0, 0, 0, 0, 0, "R9");
    step(2'b01, 0, 1, 0, 0, 1, "R9");
    step(2'b01, 0, 0, 0, 0, 1, "R9");
    idle("R9");
    // zero budget: finished straight from reset
    doReset(1, 0);
    step(2'b01, 0, 0, 0, 0, 1, "R9");
    // K of one: eat on the first still step
    doReset(1, 5);
    step(2'b01, 0, 0, 0, 0, 1, "R5");
    step(2'b01, 0, 0, 0, 0, 0, "R2");
    step(2'b01, 0, 0, 0, 0, 0, "R4");
    step(2'b01, 0, 0, 0, 0, 1, "R6");
    step(2'b00, 0, 0, 0, 0, 0, "R3");
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule